// File: doc/BRIEF.md
# Shared-Bus Accumulator Processor

This block is a very small 8-bit processor in which every register transfer travels over one internal bus. A 4-bit program counter selects one of 16 RAM words. The fetched byte goes to an instruction register. Its upper nibble is the opcode and its lower nibble is a RAM address. The core has an accumulator, an operand register, an adder that always forms their sum, and an output register whose value and update pulse are the only results seen from outside.

Each step of an instruction moves one value from one bus source into one or more destinations on one clock edge. A fetch takes three steps:
- the program counter goes to the address register,
- RAM goes to the instruction register,
- the program counter advances.

Execution then takes between zero and three further steps, depending on the opcode. There are no jumps and no halt, so the program counter simply wraps.

The program and its data are written through a preload port while synchronous reset is held. The program starts on the first clock edge after reset is released.

Top module: `acc_bus_cpu`

## Requirements
- R1: An instruction byte holds the opcode in bits 7:4 and a RAM address in bits 3:0. Opcode 4'b0000 (load) copies the addressed RAM word into the accumulator.
- R2: Opcode 4'b0001 (add) replaces the accumulator with the accumulator plus the addressed RAM word, modulo 256, with no carry kept.
- R3: Opcode 4'b1110 (output) copies the accumulator into `outValue` and ignores bits 3:0. `outStrobe` is high for exactly the one cycle after each update.
- R4: A fetch takes 3 cycles. Execution then takes 2 cycles for load, 3 for add, 1 for output, and 0 for every other opcode. Other opcodes change no register.
- R5: After reset is released, the first fetch step happens on the first rising edge. With load, add and output at addresses 0, 1 and 2, `outStrobe` is first seen high after the 15th edge.
- R6: While `rst` is high at an edge, the program counter, accumulator, operand register, instruction register and output register are cleared, and `outStrobe` is low.
- R7: The preload port writes RAM only on edges where `rst` is high and is ignored otherwise. RAM contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; preload is allowed while high |
| loadEn | input | 1 | RAM preload write enable |
| loadAddr | input | 4 | RAM preload address |
| loadData | input | 8 | RAM preload data |
| outValue | output | 8 | Output register |
| outStrobe | output | 1 | High for one cycle after `outValue` is written |

## Verification
Every program runs a fixed instruction pattern: load, add, output, add, output with a nonzero low nibble, an undefined opcode, and output. Several operand pairs are used: small values, values whose sum wraps past 255, and all-ones values.

The operand pairs separate correct addition and modulo wrap from sign or carry mistakes. The position of each strobe in cycles separates the per-opcode step counts. An unchanged third output shows that the undefined opcode did nothing.

Directed runs check three further behaviours:
- a reset in the middle of a program clears the output but keeps the RAM;
- a preload write issued while the core runs is ignored;
- the strobe lasts exactly one cycle.

// File: rtl/acc_bus_pkg.sv
package acc_bus_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int OPC_W  = DATA_W - ADDR_W;

  // one-hot bus source positions
  localparam int NSRC    = 5;
  localparam int SRC_PC  = 0;
  localparam int SRC_RAM = 1;
  localparam int SRC_IR  = 2;
  localparam int SRC_ALU = 3;
  localparam int SRC_ACC = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_OUT  = 4'b1110;

  typedef struct packed {
    logic [NSRC-1:0] srcSel;
    logic            dstMar;
    logic            dstIr;
    logic            dstAcc;
    logic            dstOpnd;
    logic            dstOut;
    logic            pcInc;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_WORD,
    ST_FETCH_INC,
    ST_EXEC_1,
    ST_EXEC_2,
    ST_EXEC_3
  } step_t;
endpackage

// File: rtl/acc_bus_control.sv
module acc_bus_control
  import acc_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);
  step_t step, stepNext;

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH_ADDR;
    else     step <= stepNext;
  end

  always_comb begin
    ctrl     = '0;
    stepNext = ST_FETCH_ADDR;
    case (step)
      ST_FETCH_ADDR: begin
        ctrl.srcSel[SRC_PC] = 1'b1;
        ctrl.dstMar         = 1'b1;
        stepNext            = ST_FETCH_WORD;
      end
      ST_FETCH_WORD: begin
        ctrl.srcSel[SRC_RAM] = 1'b1;
        ctrl.dstIr           = 1'b1;
        stepNext             = ST_FETCH_INC;
      end
      ST_FETCH_INC: begin
        ctrl.pcInc = 1'b1;
        if (opcode == OPC_LOAD || opcode == OPC_ADD || opcode == OPC_OUT)
          stepNext = ST_EXEC_1;
        else
          stepNext = ST_FETCH_ADDR;
      end
      ST_EXEC_1: begin
        if (opcode == OPC_OUT) begin
          ctrl.srcSel[SRC_ACC] = 1'b1;
          ctrl.dstOut          = 1'b1;
          stepNext             = ST_FETCH_ADDR;
        end else begin
          ctrl.srcSel[SRC_IR] = 1'b1;
          ctrl.dstMar         = 1'b1;
          stepNext            = ST_EXEC_2;
        end
      end
      ST_EXEC_2: begin
        ctrl.srcSel[SRC_RAM] = 1'b1;
        if (opcode == OPC_ADD) begin
          ctrl.dstOpnd = 1'b1;
          stepNext     = ST_EXEC_3;
        end else begin
          ctrl.dstAcc  = 1'b1;
          stepNext     = ST_FETCH_ADDR;
        end
      end
      ST_EXEC_3: begin
        ctrl.srcSel[SRC_ALU] = 1'b1;
        ctrl.dstAcc          = 1'b1;
        stepNext             = ST_FETCH_ADDR;
      end
      default: stepNext = ST_FETCH_ADDR;
    endcase
  end

  // R4: at most one driver on the bus in any step
  p_one_source_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl.srcSel));

  // R4: a fetch always walks its three steps in order
  p_fetch_order_r4: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH_ADDR) |=> (step == ST_FETCH_WORD));

  p_fetch_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH_WORD) |=> (step == ST_FETCH_INC));
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath
  import acc_bus_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             loadEn,
  input  logic [AW-1:0]    loadAddr,
  input  logic [DW-1:0]    loadData,
  output logic [DW-AW-1:0] opcode,
  output logic [DW-1:0]    outValue,
  output logic             outStrobe
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, accA, regB, ramWord, aluSum, bus;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] srcVal [NSRC];

  // RAM: preload only during reset, asynchronous read at the address register
  always_ff @(posedge clk) begin
    if (rst && loadEn) mem[loadAddr] <= loadData;
  end
  assign ramWord = mem[mar];

  assign aluSum = accA + regB;
  assign opcode = ir[DW-1:AW];

  assign srcVal[SRC_PC]  = {{(DW-AW){1'b0}}, pc};
  assign srcVal[SRC_RAM] = ramWord;
  assign srcVal[SRC_IR]  = {{(DW-AW){1'b0}}, ir[AW-1:0]};
  assign srcVal[SRC_ALU] = aluSum;
  assign srcVal[SRC_ACC] = accA;

  // wired-OR bus: each source gated by its select bit, zero when none selected
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++)
      bus = bus | ({DW{ctrl.srcSel[i]}} & srcVal[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      mar       <= '0;
      ir        <= '0;
      accA      <= '0;
      regB      <= '0;
      outValue  <= '0;
      outStrobe <= 1'b0;
    end else begin
      if (ctrl.pcInc)   pc       <= pc + 1'b1;
      if (ctrl.dstMar)  mar      <= bus[AW-1:0];
      if (ctrl.dstIr)   ir       <= bus;
      if (ctrl.dstAcc)  accA     <= bus;
      if (ctrl.dstOpnd) regB     <= bus;
      if (ctrl.dstOut)  outValue <= bus;
      outStrobe <= ctrl.dstOut;
    end
  end

  // R6: reset clears the architectural registers
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> (pc == '0 && accA == '0 && regB == '0 && ir == '0 && outValue == '0 && !outStrobe));

  // R1: a load step puts the addressed RAM word into the accumulator
  p_load_acc_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dstAcc && ctrl.srcSel[SRC_RAM]) |=> (accA == $past(ramWord)));

  // R2: an ALU step writes the wrapped sum of both operands
  p_add_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dstAcc && ctrl.srcSel[SRC_ALU]) |=> (accA == DW'($past(accA) + $past(regB))));

  // R3: an output step shows the accumulator with a one-cycle strobe
  p_out_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl.dstOut |=> (outStrobe && outValue == $past(accA)));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    !ctrl.dstOut |=> !outStrobe);
endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
  import acc_bus_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  logic [DW-1:0] loadData,
  output logic [DW-1:0] outValue,
  output logic          outStrobe
);
  ctrl_t             ctrl;
  logic [DW-AW-1:0]  opcode;

  acc_bus_control u_control (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  acc_bus_datapath #(.DW(DW), .AW(AW)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .loadEn    (loadEn),
    .loadAddr  (loadAddr),
    .loadData  (loadData),
    .opcode    (opcode),
    .outValue  (outValue),
    .outStrobe (outStrobe)
  );
endmodule

// File: tb/test_acc_bus_cpu.sv
`timescale 1ns/1ps
module test_acc_bus_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [3:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [7:0] outValue;
  logic       outStrobe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  acc_bus_cpu i_acc_bus_cpu (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .outValue(outValue), .outStrobe(outStrobe)
  );

  // {a, b, a+b, a+2b}
  localparam logic [31:0] VECS [5] = '{
    {8'h03, 8'h04, 8'h07, 8'h0B},
    {8'h00, 8'h00, 8'h00, 8'h00},
    {8'hF0, 8'h20, 8'h10, 8'h30},
    {8'hFF, 8'hFF, 8'hFE, 8'hFD},
    {8'h81, 8'h7F, 8'h00, 8'h7F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // preload while reset is held
  task automatic loadProgram(input logic [7:0] a, input logic [7:0] b);
    rst = 1'b1;
    poke(4'd0, 8'h0E);  // load [14]
    poke(4'd1, 8'h1F);  // add  [15]
    poke(4'd2, 8'hE0);  // output
    poke(4'd3, 8'h1F);  // add  [15]
    poke(4'd4, 8'hE7);  // output, nonzero low nibble
    poke(4'd5, 8'h7F);  // undefined opcode
    poke(4'd6, 8'hE3);  // output
    for (int i = 7; i < 14; i++) poke(4'(i), 8'hF0);
    poke(4'd14, a);
    poke(4'd15, b);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  // wait for the next strobe; returns the edge count at which it appeared
  task automatic waitStrobe(output int at);
    at = -1;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      cyc++;
      if (outStrobe) begin at = cyc; break; end
    end
  endtask

  task automatic runVector(input logic [31:0] v);
    int at;
    loadProgram(v[31:24], v[23:16]);
    release_reset();
    waitStrobe(at);
    check("R5 first strobe edge", at, 15);
    check("R1/R2 load+add sum", outValue, v[15:8]);
    waitStrobe(at);
    check("R4 add+output cycles", at, 25);
    check("R2/R3 second sum, low nibble ignored", outValue, v[7:0]);
    waitStrobe(at);
    check("R4 undefined opcode adds 3 cycles", at, 32);
    check("R4 undefined opcode changes nothing", outValue, v[7:0]);
    @(posedge clk); #1;
    check("R3 strobe lasts one cycle", outStrobe, 0);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int at;
    // R6: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset outValue", outValue, 0);
    check("R6 reset outStrobe", outStrobe, 0);

    foreach (VECS[i]) runVector(VECS[i]);

    // R6/R7: reset mid-program clears outputs, RAM survives
    loadProgram(8'h11, 8'h22);
    release_reset();
    waitStrobe(at);
    check("R1 pre-reset sum", outValue, 8'h33);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R6 mid-run reset clears outValue", outValue, 0);
    check("R6 mid-run reset strobe low", outStrobe, 0);
    release_reset();
    waitStrobe(at);
    check("R7 RAM kept across reset timing", at, 15);
    check("R7 RAM kept across reset value", outValue, 8'h33);

    // R7: preload while running is ignored
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    release_reset();
    @(posedge clk); #1; cyc++;
    loadEn = 1'b1; loadAddr = 4'd14; loadData = 8'h99;
    @(posedge clk); #1; cyc++;
    loadEn = 1'b0;
    waitStrobe(at);
    check("R7 running preload ignored timing", at, 15);
    check("R7 running preload ignored value", outValue, 8'h33);
    // rerun to confirm RAM word 14 still holds its old value
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    release_reset();
    waitStrobe(at);
    check("R7 RAM unchanged after running write", outValue, 8'h33);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule